// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Sequencer for an ECC-Protected Memory

This block sits between a user write port and a memory port whose native word holds 64 data bits and 8 SECDED check bits. A write request carries a word address, 64 data bits and an 8-bit byte-lane enable. When every lane is enabled, the block encodes the data and issues one memory write at once.

When only some lanes are enabled, the block runs an atomic sequence. It reads the burst that holds the target word and keeps the target beat. It corrects a single-bit error in that beat. It then overlays the enabled user bytes, recomputes the check bits and writes the word back. A double-bit error in the target word cancels the write-back and returns an error response. A request with no lane enabled completes without touching memory.

Locations must hold valid code words before a partial write reaches them, because the merge reads and checks the old contents. Other beats of the burst are fetched but never checked.

Top module: `pwrmw_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1 and mem_cmd_valid, rsp_valid, ecc_single and ecc_double are 0.
- R2: A stored word keeps the data in bits [63:0] and the check bits in [71:64]. Data bits, in ascending order, take the Hamming positions 1..71 that are not powers of two. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R3: A request with mask 8'hFF issues exactly one command, a write of the freshly encoded word to req_addr, with no read. rsp_valid with rsp_err=0 follows one cycle after that write handshake.
- R4: A request with a mask other than 8'h00 and 8'hFF first issues one read command to the burst-aligned address, which is req_addr with its low log2(BURST_BEATS) bits cleared. It then takes BURST_BEATS beats on mem_rvalid and keeps beat number req_addr mod BURST_BEATS. Finally it writes to req_addr the encoded word in which byte i comes from req_wdata when mask bit i is 1, and from the read word otherwise.
- R5: A single-bit error in the kept beat is corrected before the merge, so the write-back carries the corrected bytes. ecc_single pulses for one cycle, with ecc_pos giving the bit in error: 0..63 for data bit n, and 64+k for check bit k.
- R6: A double-bit error in the kept beat produces no write command. ecc_double pulses and the response returns with rsp_err=1 in the same cycle.
- R7: A request with mask 8'h00 returns rsp_valid with rsp_err=0 on the cycle after acceptance, and issues no memory command.
- R8: From the acceptance of a request that has a nonzero mask until its response, req_ready stays 0.
- R9: While mem_cmd_valid is 1 and mem_cmd_ready is 0, mem_cmd_valid, mem_cmd_write, mem_cmd_addr and mem_cmd_wdata hold their values into the next cycle.
- R10: Errors in beats other than the kept one raise neither ecc_single nor ecc_double, and do not change the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User write request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | Word address of the write |
| req_wdata | input | 64 | User write data |
| req_mask | input | 8 | Byte-lane enables, bit i covers bits 8i+7..8i |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion aborted on an uncorrectable error |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_write | output | 1 | 1 for write, 0 for burst read |
| mem_cmd_addr | output | ADDR_W | Command word address |
| mem_cmd_wdata | output | 72 | Code word to write |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 72 | Read beat code word |
| ecc_single | output | 1 | Corrected single-bit error pulse |
| ecc_double | output | 1 | Uncorrectable error pulse |
| ecc_pos | output | 7 | Position of the corrected bit |

## Verification
The bench builds the block with BURST_BEATS=4 and ADDR_W=8. With a short burst, partial writes land on every beat slot, so the first, a middle and the last beat are each used as the kept word. With a small address space, the bench's memory model can hold every location as a code word. The model stalls commands and read beats in patterns that do not line up. This exercises command hold, beat counting across gaps, and errors injected into both the kept word and its burst neighbours.

// File: rtl/pwrmw_pkg.sv
package pwrmw_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_WR_CMD
    } seq_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single;
        logic              dbl;
        logic [6:0]        pos;
    } dec_result_t;

    // Extended Hamming check bits: data fills the non-power-of-two positions 1..71
    function automatic logic [CHK_W-1:0] chk_gen(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        int               idx;
        c   = '0;
        idx = 0;
        for (int p = 1; p < WORD_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < 7; k++) begin
                    if (p[k]) c[k] = c[k] ^ d[idx[5:0]];
                end
                idx++;
            end
        end
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    function automatic dec_result_t chk_decode(input logic [WORD_W-1:0] w);
        dec_result_t      r;
        logic [CHK_W-1:0] fresh;
        logic [6:0]       syn;
        logic             odd;
        logic             hit;
        int               idx;
        r.data   = w[DATA_W-1:0];
        r.single = 1'b0;
        r.dbl    = 1'b0;
        r.pos    = '0;
        hit      = 1'b0;
        idx      = 0;
        fresh    = chk_gen(w[DATA_W-1:0]);
        syn      = fresh[6:0] ^ w[DATA_W+6:DATA_W];
        odd      = ^w;
        if (odd) begin
            r.single = 1'b1;
            if (syn == 7'd0) begin
                r.pos = 7'(DATA_W + 7);
            end else if ($onehot(syn)) begin
                for (int k = 0; k < 7; k++) begin
                    if (syn[k]) r.pos = 7'(DATA_W + k);
                end
            end else begin
                for (int p = 1; p < WORD_W; p++) begin
                    if ((p & (p - 1)) != 0) begin
                        if (7'(p) == syn) begin
                            r.data[idx[5:0]] = ~w[idx[5:0]];
                            r.pos            = 7'(idx);
                            hit              = 1'b1;
                        end
                        idx++;
                    end
                end
                if (!hit) begin
                    r.single = 1'b0;
                    r.dbl    = 1'b1;
                end
            end
        end else if (syn != 7'd0) begin
            r.dbl = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pwrmw_decoder.sv
module pwrmw_decoder
    import pwrmw_pkg::*;
(
    input  logic [WORD_W-1:0] code_in,
    output dec_result_t       result
);

    always_comb result = chk_decode(code_in);

endmodule

// File: rtl/pwrmw_merge.sv
module pwrmw_merge
    import pwrmw_pkg::*;
(
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] upd,
    input  logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] coded
);

    logic [DATA_W-1:0] merged;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*8 +: 8] = lane_en[i] ? upd[i*8 +: 8] : base[i*8 +: 8];
    end

    assign coded = {chk_gen(merged), merged};

endmodule

// File: rtl/pwrmw_beat_capture.sv
module pwrmw_beat_capture
    import pwrmw_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    input  logic [BEAT_W-1:0] target,
    output logic [WORD_W-1:0] captured,
    output logic              done
);

    logic              active;
    logic [BEAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            captured <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active && beat_valid) begin
                if (cnt == target) captured <= beat_data;
                cnt <= cnt + 1'b1;
                if (cnt == BEAT_W'(BEATS - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R4: the burst ends only on a received beat
    assert_done_on_beat_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(beat_valid));

endmodule

// File: rtl/pwrmw_sequencer.sv
module pwrmw_sequencer
    import pwrmw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BURST_BEATS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [LANES-1:0]    req_mask,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic                mem_cmd_valid,
    input  logic                mem_cmd_ready,
    output logic                mem_cmd_write,
    output logic [ADDR_W-1:0]   mem_cmd_addr,
    output logic [WORD_W-1:0]   mem_cmd_wdata,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                ecc_single,
    output logic                ecc_double,
    output logic [6:0]          ecc_pos
);

    localparam int BEAT_W = $clog2(BURST_BEATS);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [WORD_W-1:0] wword_q;
    logic [WORD_W-1:0] cap_word;
    logic              cap_done;
    dec_result_t       dec;
    logic [WORD_W-1:0] merged_code;
    logic [ADDR_W-1:0] burst_addr;

    assign burst_addr    = {addr_q[ADDR_W-1:BEAT_W], {BEAT_W{1'b0}}};
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_cmd_valid = (state_q == ST_RD_CMD) || (state_q == ST_WR_CMD);
    assign mem_cmd_write = (state_q == ST_WR_CMD);
    assign mem_cmd_addr  = mem_cmd_write ? addr_q : burst_addr;
    assign mem_cmd_wdata = wword_q;

    pwrmw_beat_capture #(.BEATS(BURST_BEATS)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .start      (state_q == ST_RD_CMD && mem_cmd_ready),
        .beat_valid (mem_rvalid),
        .beat_data  (mem_rdata),
        .target     (addr_q[BEAT_W-1:0]),
        .captured   (cap_word),
        .done       (cap_done)
    );

    pwrmw_decoder u_decoder (
        .code_in (cap_word),
        .result  (dec)
    );

    pwrmw_merge u_merge (
        .base    (dec.data),
        .upd     (wdata_q),
        .lane_en (mask_q),
        .coded   (merged_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            wdata_q    <= '0;
            mask_q     <= '0;
            wword_q    <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            ecc_single <= 1'b0;
            ecc_double <= 1'b0;
            ecc_pos    <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            ecc_single <= 1'b0;
            ecc_double <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        mask_q  <= req_mask;
                        if (req_mask == '0) begin
                            rsp_valid <= 1'b1;
                        end else if (req_mask == '1) begin
                            wword_q <= {chk_gen(req_wdata), req_wdata};
                            state_q <= ST_WR_CMD;
                        end else begin
                            state_q <= ST_RD_CMD;
                        end
                    end
                end
                ST_RD_CMD: begin
                    if (mem_cmd_ready) state_q <= ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    if (cap_done) begin
                        if (dec.dbl) begin
                            ecc_double <= 1'b1;
                            rsp_valid  <= 1'b1;
                            rsp_err    <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            if (dec.single) begin
                                ecc_single <= 1'b1;
                                ecc_pos    <= dec.pos;
                            end
                            wword_q <= merged_code;
                            state_q <= ST_WR_CMD;
                        end
                    end
                end
                ST_WR_CMD: begin
                    if (mem_cmd_ready) begin
                        rsp_valid <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a stalled command keeps its contents
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_write)
            && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata));

    // R7: empty mask answers next cycle without a memory command
    assert_zero_mask_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mask == '0 |=> rsp_valid && !rsp_err && !mem_cmd_valid);

    // R3: full mask goes straight to a write
    assert_full_direct_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mask == '1 |=> mem_cmd_valid && mem_cmd_write);

    // R3: a finished write is answered without error
    assert_write_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid && mem_cmd_ready && mem_cmd_write |=> rsp_valid && !rsp_err);

    // R4: a partial mask starts with a read
    assert_partial_read_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mask != '0 && req_mask != '1
            |=> mem_cmd_valid && !mem_cmd_write);

    // R6: an error response always comes with the double-error flag
    assert_err_double_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_err |-> ecc_double);

    // R5: single and double flags never coincide
    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(ecc_single && ecc_double));

    // R8: busy after accepting a nonzero mask
    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_mask != '0 |=> !req_ready);

endmodule

// File: tb/pwrmw_sequencer_test.sv
module pwrmw_sequencer_test;

    localparam int AW    = 8;
    localparam int BEATS = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_mask = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic          mem_cmd_valid;
    logic          mem_cmd_ready = 1'b0;
    logic          mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [71:0]   mem_cmd_wdata;
    logic          mem_rvalid = 1'b0;
    logic [71:0]   mem_rdata = '0;
    logic          ecc_single;
    logic          ecc_double;
    logic [6:0]    ecc_pos;

    always #4 clk = ~clk;

    pwrmw_sequencer #(.ADDR_W(AW), .BURST_BEATS(BEATS)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_wdata(mem_cmd_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ecc_single(ecc_single), .ecc_double(ecc_double), .ecc_pos(ecc_pos)
    );

    logic [71:0]   tb_mem [DEPTH];
    logic [63:0]   clean  [DEPTH];
    int            posmap [64];
    int            total = 0;
    int            bad = 0;
    int            cyc = 0;
    int            rd_left = 0;
    int            rd_base = 0;
    int            rd_idx = 0;
    int            sgl_cnt = 0;
    int            dbl_cnt = 0;
    int            rsp_seen = 0;
    logic [6:0]    last_pos = '0;
    bit            stall_prev = 1'b0;
    logic [AW-1:0] stall_addr;
    logic [71:0]   stall_data;
    logic          stall_wr;

    logic [AW-1:0] q_rd_addr[$];
    logic [AW-1:0] q_wr_addr[$];
    logic [71:0]   q_wr_word[$];
    logic          q_rsp_err[$];

    function automatic logic [71:0] tb_code(input logic [63:0] d);
        logic [7:0] c;
        c = '0;
        for (int k = 0; k < 7; k++)
            for (int n = 0; n < 64; n++)
                if ((posmap[n] >> k) & 1) c[k] ^= d[n];
        c[7] = (^d) ^ (^c[6:0]);
        return {c, d};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory model and monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rsp_valid) begin
                rsp_seen++;
                if (q_rsp_err.size() == 0) begin
                    check(1'b0, "R7", "unexpected response", 72'(rsp_err), 72'd0);
                end else begin
                    logic e;
                    e = q_rsp_err.pop_front();
                    check(rsp_err == e, e ? "R6" : "R3", "response error flag",
                          72'(rsp_err), 72'(e));
                end
            end
            if (ecc_single) begin
                sgl_cnt++;
                last_pos = ecc_pos;
            end
            if (ecc_double) dbl_cnt++;
            if (stall_prev) begin
                check(mem_cmd_valid && mem_cmd_write == stall_wr && mem_cmd_addr == stall_addr
                      && mem_cmd_wdata == stall_data, "R9", "stalled command changed",
                      mem_cmd_wdata, stall_data);
            end
            if (rd_left > 0 && (cyc % 5) != 2) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tb_mem[rd_base + rd_idx];
                rd_idx++;
                rd_left--;
            end else begin
                mem_rvalid = 1'b0;
            end
            mem_cmd_ready = (cyc % 3) != 1;
            stall_prev = mem_cmd_valid && !mem_cmd_ready;
            stall_addr = mem_cmd_addr;
            stall_data = mem_cmd_wdata;
            stall_wr   = mem_cmd_write;
            if (mem_cmd_valid && mem_cmd_ready) begin
                if (mem_cmd_write) begin
                    if (q_wr_addr.size() == 0) begin
                        check(1'b0, "R6", "unexpected write", mem_cmd_wdata, 72'd0);
                    end else begin
                        logic [AW-1:0] ea;
                        logic [71:0]   ew;
                        ea = q_wr_addr.pop_front();
                        ew = q_wr_word.pop_front();
                        check(mem_cmd_addr == ea, "R4", "write address", 72'(mem_cmd_addr), 72'(ea));
                        check(mem_cmd_wdata == ew, "R4", "write word", mem_cmd_wdata, ew);
                    end
                    tb_mem[mem_cmd_addr] = mem_cmd_wdata;
                end else begin
                    if (q_rd_addr.size() == 0) begin
                        check(1'b0, "R3", "unexpected read", 72'(mem_cmd_addr), 72'd0);
                    end else begin
                        logic [AW-1:0] ra;
                        ra = q_rd_addr.pop_front();
                        check(mem_cmd_addr == ra, "R4", "read burst address",
                              72'(mem_cmd_addr), 72'(ra));
                    end
                    rd_base = int'(mem_cmd_addr);
                    rd_idx  = 0;
                    rd_left = BEATS;
                end
            end
        end
    end

    task automatic do_op(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] m,
                         input int fa, input int fb, input string tag);
        int            exp_s;
        int            exp_d;
        int            exp_pos;
        int            target;
        bit            busy_bad;
        logic [63:0]   mg;
        exp_s = 0; exp_d = 0; exp_pos = 0; busy_bad = 1'b0;
        if (fa >= 0) tb_mem[a][fa] = ~tb_mem[a][fa];
        if (fb >= 0) tb_mem[a][fb] = ~tb_mem[a][fb];
        if (m == 8'h00) begin
            q_rsp_err.push_back(1'b0);
        end else if (m == 8'hFF) begin
            q_wr_addr.push_back(a);
            q_wr_word.push_back(tb_code(d));
            q_rsp_err.push_back(1'b0);
            clean[a] = d;
        end else begin
            q_rd_addr.push_back(a & ~AW'(BEATS - 1));
            if (fa >= 0 && fb >= 0) begin
                q_rsp_err.push_back(1'b1);
                exp_d = 1;
            end else begin
                mg = clean[a];
                for (int i = 0; i < 8; i++) if (m[i]) mg[i*8 +: 8] = d[i*8 +: 8];
                q_wr_addr.push_back(a);
                q_wr_word.push_back(tb_code(mg));
                q_rsp_err.push_back(1'b0);
                clean[a] = mg;
                if (fa >= 0) begin
                    exp_s   = 1;
                    exp_pos = fa;
                end
            end
        end
        sgl_cnt = 0;
        dbl_cnt = 0;
        target  = rsp_seen + 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        while (rsp_seen < target) begin
            if (req_ready && !rsp_valid) busy_bad = 1'b1;
            @(negedge clk);
            #1;
        end
        if (m != 8'h00) check(!busy_bad, "R8", {tag, " ready while busy"}, 72'(busy_bad), 72'd0);
        check(sgl_cnt == exp_s, exp_s != 0 ? "R5" : "R10", {tag, " single flag count"},
              72'(sgl_cnt), 72'(exp_s));
        check(dbl_cnt == exp_d, exp_d != 0 ? "R6" : "R10", {tag, " double flag count"},
              72'(dbl_cnt), 72'(exp_d));
        if (exp_s != 0) check(int'(last_pos) == exp_pos, "R5", {tag, " error position"},
                              72'(last_pos), 72'(exp_pos));
        check(q_wr_addr.size() == 0 && q_rd_addr.size() == 0, "R4", {tag, " commands missing"},
              72'(q_wr_addr.size() + q_rd_addr.size()), 72'd0);
        if (exp_d != 0) tb_mem[a] = tb_code(clean[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        begin
            int p;
            p = 1;
            for (int n = 0; n < 64; n++) begin
                while ((p & (p - 1)) == 0) p++;
                posmap[n] = p;
                p++;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            clean[i]  = '0;
            tb_mem[i] = tb_code(64'd0);
        end
        repeat (3) @(negedge clk);
        check(req_ready && !mem_cmd_valid && !rsp_valid && !ecc_single && !ecc_double,
              "R1", "outputs during reset",
              72'({req_ready, mem_cmd_valid, rsp_valid, ecc_single, ecc_double}), 72'b10000);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_cmd_valid && !rsp_valid && !ecc_single && !ecc_double,
              "R1", "outputs after reset",
              72'({req_ready, mem_cmd_valid, rsp_valid, ecc_single, ecc_double}), 72'b10000);

        // R2: fixed code words at the ends of the data range
        check(tb_code(64'h1) == 72'h83_0000000000000001, "R2", "bench code of bit 0",
              tb_code(64'h1), 72'h83_0000000000000001);
        do_op(8'd8, 64'h1, 8'hFF, -1, -1, "R2");
        check(tb_mem[8] == 72'h83_0000000000000001, "R2", "stored code of bit 0",
              tb_mem[8], 72'h83_0000000000000001);
        do_op(8'd9, 64'h8000_0000_0000_0000, 8'hFF, -1, -1, "R2");
        check(tb_mem[9] == 72'hC7_8000000000000000, "R2", "stored code of bit 63",
              tb_mem[9], 72'hC7_8000000000000000);

        // R3: full writes fill a burst group
        do_op(8'd4, 64'h0123_4567_89AB_CDEF, 8'hFF, -1, -1, "R3");
        do_op(8'd5, 64'hFEDC_BA98_7654_3210, 8'hFF, -1, -1, "R3");
        do_op(8'd6, 64'hA5A5_5A5A_F00F_0FF0, 8'hFF, -1, -1, "R3");
        do_op(8'd7, 64'h1111_2222_3333_4444, 8'hFF, -1, -1, "R3");

        // R4: partial writes on first, middle and last beat
        do_op(8'd6, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F, -1, -1, "R4");
        do_op(8'd4, 64'h7777_7777_7777_7777, 8'h81, -1, -1, "R4");
        do_op(8'd7, 64'h0000_0000_0000_0000, 8'h3C, -1, -1, "R4");

        // R5: single errors in data and check bits are corrected
        do_op(8'd5, 64'h0000_0000_0000_AB00, 8'h02, 13, -1, "R5");
        do_op(8'd6, 64'h0000_0099_0000_0000, 8'h10, 67, -1, "R5");
        do_op(8'd7, 64'h5500_0000_0000_0000, 8'h80, 71, -1, "R5");
        do_op(8'd4, 64'h0000_0000_0000_0012, 8'h01, 63, -1, "R5");

        // R6: double error aborts
        do_op(8'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0, 2, 40, "R6");
        do_op(8'd5, 64'h0000_0000_0000_0000, 8'h01, 64, 30, "R6");

        // R7: empty mask
        do_op(8'd6, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, -1, -1, "R7");

        // R10: corrupt neighbours in the burst, then write the middle word
        tb_mem[4][0] = ~tb_mem[4][0];
        tb_mem[4][1] = ~tb_mem[4][1];
        tb_mem[7][50] = ~tb_mem[7][50];
        do_op(8'd5, 64'h00CC_0000_0000_0000, 8'h40, -1, -1, "R10");
        tb_mem[4] = tb_code(clean[4]);
        tb_mem[7] = tb_code(clean[7]);

        // mixed traffic over a wider range
        lf = 32'hACE1_2357;
        for (int t = 0; t < 24; t++) begin
            logic [AW-1:0] a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = AW'(16 + (lf[4:0]));
            do_op(a, {lf, ~lf}, lf[15:8], (t % 4 == 1) ? int'(lf[22:17]) : -1, -1, "R4");
        end

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule